// File: doc/BRIEF.md
# UART Interrupt Priority Encoder

This block collects the interrupt sources of a 16550-style serial controller and folds them into one interrupt identification byte and one level-high interrupt request. It watches the line status flags, the receive FIFO fill level against its trigger threshold, a character-timeout flag and the modem-status change flags. It holds two pieces of state of its own: the 4-bit interrupt enable value, and a hidden "transmitter empty" pending flag that register accesses set and clear.

The surrounding controller drives the inputs as plain levels and issues single-cycle strobes for the relevant register accesses: enable write, identification read, holding-register write and "transmitter drained". All inputs here are control and status, so the block has no streaming interface and no back-pressure. The identification byte and the request line are registered. Both follow any input change one clock edge later.

Top module: `uart_irq_prio`

## Requirements
- R1: When several sources are active, the one reported is the highest in this order: line status, character timeout, received data, transmitter empty, modem status.
- R2: `iir[3:0]` reads 0x6 for line status, 0xC for timeout, 0x4 for received data, 0x2 for transmitter empty, 0x0 for modem status and 0x1 when no source is active.
- R3: A line status interrupt needs enable bit 2 together with at least one of `lsr_flags[4:1]` (overrun, parity, framing, break). The data-ready flag `lsr_flags[0]` alone never raises a line status interrupt.
- R4: The character timeout interrupt is raised by `rx_timeout` only while enable bit 0 (received data) is set. It has no enable of its own.
- R5: The received-data interrupt needs enable bit 0 and `lsr_flags[0]`. With `fifo_en` high it also needs `rx_count >= rx_trig`. With `fifo_en` low the data-ready flag alone is enough. A received-data source held back by the threshold does not hide lower-priority sources.
- R6: An `iir_rd` strobe or a `thr_wr` strobe clears the transmitter-empty pending flag.
- R7: An `ier_wr` strobe stores `ier_wdata` as the enable value, with bit 0 for received data, bit 1 for transmitter empty, bit 2 for line status and bit 3 for modem status. If `thr_empty` is high in that cycle, the strobe also sets the pending flag. A `tx_drained` strobe always sets the pending flag. When a set and a clear arrive in the same cycle, the set wins.
- R8: `iir[7:6]` reads 2'b11 while `fifo_en` is high and 2'b00 otherwise. `iir[5:4]` always read 0.
- R9: `irq` is high exactly when `iir[3:0]` is not 0x1.
- R10: `iir` and `irq` change on the clock edge after the inputs or the internal state change. After reset, `iir` is 0x01 and `irq` is low.
- R11: A modem status interrupt needs enable bit 3 and any bit of `msr_delta` set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ier_wr | input | 1 | Interrupt enable write strobe |
| ier_wdata | input | 4 | Enable value written by `ier_wr` |
| iir_rd | input | 1 | Identification register read strobe |
| thr_wr | input | 1 | Holding register write strobe |
| tx_drained | input | 1 | Strobe: the transmitter has just emptied |
| thr_empty | input | 1 | Level: the holding register is empty |
| lsr_flags | input | 5 | Line status: bit0 data ready, bit1 overrun, bit2 parity, bit3 framing, bit4 break |
| rx_count | input | CNT_W | Receive FIFO fill level |
| rx_trig | input | CNT_W | Receive FIFO trigger threshold |
| fifo_en | input | 1 | FIFOs enabled |
| rx_timeout | input | 1 | Character timeout pending |
| msr_delta | input | 4 | Modem status change flags |
| iir | output | 8 | Interrupt identification byte |
| irq | output | 1 | Interrupt request, high active |

## Verification
The bench uses the default `CNT_W` of 5. This lets the fill level span the full 0 to 16 range of a 16-deep FIFO, so thresholds of 1, 4, 8 and 14 can be approached from below, met exactly and exceeded up to a full FIFO. Directed cases step down the priority ladder one source at a time. They also cover each enable bit on its own, the pending-flag set and clear paths, and the one-edge latency. Seeded random cycles then mix all sources with random strobes against a bench model.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NUM_SRC = 5;

  // source index order is the priority order, index 0 highest
  localparam int SRC_LINE = 0;
  localparam int SRC_TMO  = 1;
  localparam int SRC_RXD  = 2;
  localparam int SRC_THR  = 3;
  localparam int SRC_MDM  = 4;

  localparam logic [3:0] ID_NONE   = 4'h1;
  localparam logic [1:0] FIFO_MARK = 2'b11;

  localparam int EN_RXD  = 0;
  localparam int EN_THR  = 1;
  localparam int EN_LINE = 2;
  localparam int EN_MDM  = 3;

  function automatic logic [3:0] src_code(input int idx);
    case (idx)
      SRC_LINE: src_code = 4'h6;
      SRC_TMO:  src_code = 4'hC;
      SRC_RXD:  src_code = 4'h4;
      SRC_THR:  src_code = 4'h2;
      default:  src_code = 4'h0;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_src.sv
module uart_irq_src
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic [3:0]         ier,
  input  logic               thr_pend,
  input  logic [4:0]         lsr_flags,
  input  logic [CNT_W-1:0]   rx_count,
  input  logic [CNT_W-1:0]   rx_trig,
  input  logic               fifo_en,
  input  logic               rx_timeout,
  input  logic [3:0]         msr_delta,
  output logic [NUM_SRC-1:0] req
);
  logic data_ready;
  logic level_met;

  assign data_ready = lsr_flags[0];
  assign level_met  = !fifo_en || (rx_count >= rx_trig);

  always_comb begin
    req           = '0;
    req[SRC_LINE] = ier[EN_LINE] && (|lsr_flags[4:1]);
    req[SRC_TMO]  = ier[EN_RXD] && rx_timeout;
    req[SRC_RXD]  = ier[EN_RXD] && data_ready && level_met;
    req[SRC_THR]  = ier[EN_THR] && thr_pend;
    req[SRC_MDM]  = ier[EN_MDM] && (|msr_delta);
  end
endmodule

// File: rtl/uart_irq_pick.sv
module uart_irq_pick
  import uart_irq_pkg::*;
(
  input  logic [NUM_SRC-1:0] req,
  output logic [3:0]         id_nib,
  output logic               any_req
);
  logic [NUM_SRC-1:0] win;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_win
    if (i == 0) begin : g_top
      assign win[i] = req[i];
    end else begin : g_rest
      assign win[i] = req[i] && !(|req[i-1:0]);
    end
  end

  assign any_req = |req;

  always_comb begin
    id_nib = any_req ? 4'h0 : ID_NONE;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (win[k]) id_nib = id_nib | src_code(k);
    end
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ier_wr,
  input  logic [3:0]       ier_wdata,
  input  logic             iir_rd,
  input  logic             thr_wr,
  input  logic             tx_drained,
  input  logic             thr_empty,
  input  logic [4:0]       lsr_flags,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_trig,
  input  logic             fifo_en,
  input  logic             rx_timeout,
  input  logic [3:0]       msr_delta,
  output logic [7:0]       iir,
  output logic             irq
);
  logic [3:0]         ier_q;
  logic               thr_pend_q;
  logic               pend_set;
  logic               pend_clr;
  logic [NUM_SRC-1:0] req;
  logic [3:0]         id_nib;
  logic               any_req;

  assign pend_set = (ier_wr && thr_empty) || tx_drained;
  assign pend_clr = iir_rd || thr_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q      <= '0;
      thr_pend_q <= 1'b0;
    end else begin
      if (ier_wr) ier_q <= ier_wdata;
      if (pend_set)      thr_pend_q <= 1'b1;
      else if (pend_clr) thr_pend_q <= 1'b0;
    end
  end

  uart_irq_src #(.CNT_W(CNT_W)) src_i (
    .ier        (ier_q),
    .thr_pend   (thr_pend_q),
    .lsr_flags  (lsr_flags),
    .rx_count   (rx_count),
    .rx_trig    (rx_trig),
    .fifo_en    (fifo_en),
    .rx_timeout (rx_timeout),
    .msr_delta  (msr_delta),
    .req        (req)
  );

  uart_irq_pick pick_i (
    .req     (req),
    .id_nib  (id_nib),
    .any_req (any_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iir <= {4'h0, ID_NONE};
      irq <= 1'b0;
    end else begin
      iir <= {(fifo_en ? FIFO_MARK : 2'b00), 2'b00, id_nib};
      irq <= any_req;
    end
  end

  AST_IRQ_MATCHES_ID: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (iir[3:0] != ID_NONE)); // R9

  AST_ID_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    iir[3:0] inside {4'h6, 4'hC, 4'h4, 4'h2, 4'h0, 4'h1}); // R2

  AST_LINE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_q[EN_LINE] && (|lsr_flags[4:1])) |=> (iir[3:0] == 4'h6)); // R1

  AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_clr && !pend_set) |=> !thr_pend_q); // R6

  AST_PEND_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_wr && thr_empty) |=> thr_pend_q); // R7

  AST_TOP_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (iir[7:4] == ($past(fifo_en) ? 4'hC : 4'h0))); // R8
endmodule

// File: tb/uart_irq_prio_tb_top.sv
module uart_irq_prio_tb_top;
  localparam int CNT_W = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ier_wr = 1'b0;
  logic [3:0]       ier_wdata = '0;
  logic             iir_rd = 1'b0;
  logic             thr_wr = 1'b0;
  logic             tx_drained = 1'b0;
  logic             thr_empty = 1'b0;
  logic [4:0]       lsr_flags = '0;
  logic [CNT_W-1:0] rx_count = '0;
  logic [CNT_W-1:0] rx_trig = 5'd1;
  logic             fifo_en = 1'b0;
  logic             rx_timeout = 1'b0;
  logic [3:0]       msr_delta = '0;
  logic [7:0]       iir;
  logic             irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [3:0] ier_m = '0;
  logic       pend_m = 1'b0;

  always #2 clk = ~clk;

  uart_irq_prio #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
    .iir_rd(iir_rd), .thr_wr(thr_wr), .tx_drained(tx_drained),
    .thr_empty(thr_empty), .lsr_flags(lsr_flags), .rx_count(rx_count),
    .rx_trig(rx_trig), .fifo_en(fifo_en), .rx_timeout(rx_timeout),
    .msr_delta(msr_delta), .iir(iir), .irq(irq)
  );

  function automatic logic [7:0] model_id();
    logic [3:0] nib;
    nib = 4'h1;
    if (ier_m[2] && (|lsr_flags[4:1]))                         nib = 4'h6;
    else if (ier_m[0] && rx_timeout)                           nib = 4'hC;
    else if (ier_m[0] && lsr_flags[0] && (!fifo_en || rx_count >= rx_trig)) nib = 4'h4;
    else if (ier_m[1] && pend_m)                               nib = 4'h2;
    else if (ier_m[3] && (|msr_delta))                         nib = 4'h0;
    return {(fifo_en ? 4'hC : 4'h0), nib};
  endfunction

  task automatic check_val(input string tag, input logic [7:0] exp_id);
    logic exp_irq;
    exp_irq = (exp_id[3:0] != 4'h1);
    n_chk++;
    if (iir !== exp_id || irq !== exp_irq) begin
      n_bad++;
      $display("FAIL %s: iir=%02h irq=%0b expected iir=%02h irq=%0b",
               tag, iir, irq, exp_id, exp_irq);
    end
  endtask

  task automatic settle_check(input string tag);
    repeat (2) @(negedge clk);
    #1 check_val(tag, model_id());
  endtask

  task automatic wr_ier(input logic [3:0] v);
    ier_wr = 1'b1; ier_wdata = v;
    @(negedge clk);
    ier_wr = 1'b0;
    ier_m = v;
    if (thr_empty) pend_m = 1'b1;
  endtask

  task automatic rd_iir();
    iir_rd = 1'b1;
    @(negedge clk);
    iir_rd = 1'b0;
    pend_m = 1'b0;
  endtask

  task automatic wr_thr();
    thr_wr = 1'b1;
    @(negedge clk);
    thr_wr = 1'b0;
    pend_m = 1'b0;
  endtask

  task automatic drained();
    tx_drained = 1'b1;
    @(negedge clk);
    tx_drained = 1'b0;
    pend_m = 1'b1;
  endtask

  task automatic clear_sources();
    lsr_flags = '0; rx_timeout = 1'b0; msr_delta = '0;
    rx_count = '0; fifo_en = 1'b0; thr_empty = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1 check_val("R10 reset value", 8'h01);
    rst_n = 1'b1;
    @(negedge clk);
    #1 check_val("R10 idle after reset", 8'h01);

    // R1 priority ladder, all enabled, every source active
    thr_empty = 1'b1;
    wr_ier(4'hF);
    lsr_flags = 5'b00011; rx_timeout = 1'b1; msr_delta = 4'b0001;
    settle_check("R1 all active -> line status");
    lsr_flags = 5'b00001;
    settle_check("R1 timeout next");
    rx_timeout = 1'b0;
    settle_check("R1 received data next");
    lsr_flags = '0;
    settle_check("R1 transmitter empty next");
    rd_iir();
    settle_check("R6 iir read clears pending, modem next");
    msr_delta = '0;
    settle_check("R2 nothing pending");

    // R10 one-edge latency
    lsr_flags = 5'b00100;
    #1 check_val("R10 before edge unchanged", 8'h01);
    @(negedge clk);
    #1 check_val("R10 after one edge", 8'h06);
    lsr_flags = '0;

    // R3 each error bit, and data-ready alone with only line enable
    thr_empty = 1'b0;
    wr_ier(4'h4);
    lsr_flags = 5'b00001;
    settle_check("R3 data ready alone no line status");
    for (int b = 1; b < 5; b++) begin
      lsr_flags = 5'b00001 << b;
      settle_check("R3 error bit raises line status");
    end
    lsr_flags = '0;

    // R4 timeout gating
    rx_timeout = 1'b1;
    wr_ier(4'hE);
    settle_check("R4 timeout masked without bit0");
    wr_ier(4'h1);
    settle_check("R4 timeout with bit0");
    rx_timeout = 1'b0;

    // R5 FIFO threshold
    fifo_en = 1'b1; lsr_flags = 5'b00001; rx_trig = 5'd8;
    rx_count = 5'd7;
    settle_check("R5 below trigger");
    rx_count = 5'd8;
    settle_check("R5 at trigger");
    rx_count = 5'd16;
    settle_check("R5 full fifo");
    rx_trig = 5'd14; rx_count = 5'd13;
    thr_empty = 1'b1;
    wr_ier(4'h3);
    settle_check("R5 held back rx does not hide tx empty");
    rd_iir();
    fifo_en = 1'b0; rx_count = 5'd0;
    settle_check("R5 fifo off data ready alone, R8 top bits");
    lsr_flags = '0;

    // R6 / R7 pending paths
    thr_empty = 1'b0;
    wr_ier(4'h2);
    settle_check("R7 write with holding reg busy no pending");
    drained();
    settle_check("R7 drained sets pending");
    wr_thr();
    settle_check("R6 holding write clears pending");
    thr_empty = 1'b1;
    wr_ier(4'h2);
    settle_check("R7 write with empty holding reg sets pending");
    thr_empty = 1'b0;

    // R11 modem status
    wr_ier(4'h8);
    msr_delta = 4'b0100;
    settle_check("R11 modem delta");
    wr_ier(4'h7);
    settle_check("R11 modem masked");
    msr_delta = '0;

    // R8 top bits
    fifo_en = 1'b1; rx_count = 5'd0;
    settle_check("R8 fifo mark on");
    clear_sources();

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      lsr_flags  = 5'($urandom_range(0, 31)) & ($urandom_range(0, 3) == 0 ? 5'h1F : 5'h01);
      rx_timeout = ($urandom_range(0, 4) == 0);
      msr_delta  = ($urandom_range(0, 2) == 0) ? 4'($urandom_range(0, 15)) : 4'h0;
      fifo_en    = 1'($urandom_range(0, 1));
      rx_count   = 5'($urandom_range(0, 16));
      case ($urandom_range(0, 3))
        0: rx_trig = 5'd1;
        1: rx_trig = 5'd4;
        2: rx_trig = 5'd8;
        default: rx_trig = 5'd14;
      endcase
      thr_empty  = 1'($urandom_range(0, 1));
      op = $urandom_range(0, 9);
      case (op)
        0, 1: wr_ier(4'($urandom_range(0, 15)));
        2:    rd_iir();
        3:    wr_thr();
        4:    drained();
        default: ;
      endcase
      settle_check("R1 R5 R9 random mix");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule